// File: doc/BRIEF.md
# SD Host Data FIFO with Watermark DMA Requests

This block is the data buffer between the processor side and the card side of an SD/MMC host controller. It holds up to 32 words of 16 bits in first-in, first-out order. The transfer direction input decides which side fills the buffer and which side drains it. When data moves from the card to the host, the card side pushes words and the processor reads the data register. When data moves from the host to the card, the processor writes the data register and the card side pops words. Both sides see the head word on a shared read-data output.

A buffer-configuration register sets two thresholds, a high mark and a low mark, and holds an enable for each of two DMA request lines. The buffer is compared against the mark that belongs to the current direction. If the DMA channel for that direction is enabled, the block raises its DMA request. If it is not enabled, the block raises the matching status flag, which goes on to the controller's interrupt status. The same condition never drives both the request and the flag. All four of these outputs are registered, so each one follows its condition one clock later. When the controller is idle and the buffer is empty, all four are forced low. A read that finds the buffer empty returns zero and sets a sticky underrun flag.

Top module: `sd_fifo_wm`

## Requirements
- R1: The buffer stores up to 32 words of 16 bits and hands them out in the order they were accepted. Both pointers wrap modulo 32. `fill_count` reports the occupancy from 0 to 32.
- R2: With `dir_rx`=1, `card_push` fills the buffer and `cpu_rd` drains it. With `dir_rx`=0, `cpu_wr` fills it and `card_pop` drains it. Strobes on the side that is not selected have no effect on the buffer.
- R3: The configuration word holds the receive DMA enable at bit 15, the high mark at bits 12:8, the transmit DMA enable at bit 7 and the low mark at bits 4:0. All other bits read back as 0. After reset the word reads 16'h1F00. A write becomes visible on `cfg_rdata` after the next clock edge.
- R4: A push is accepted only if the occupancy before the edge is below 32. If a push and a pop arrive together while the buffer is full, the pop is taken, the push is dropped, and the occupancy becomes 31.
- R5: `rd_data` always shows the head word, or 0 when the buffer is empty. A pop on a buffer that is not empty removes the head at the clock edge.
- R6: A pop on an empty buffer does not move the buffer and sets `underrun`. `underrun` stays set until reset.
- R7: With `dir_rx`=1 and an occupancy greater than the high mark, the outputs change one clock later. If receive DMA is enabled, `dma_rx_req` goes high and `stat_af` stays low. Otherwise `stat_af` goes high. Both outputs are low one clock after the condition stops.
- R8: With `dir_rx`=0 and an occupancy less than the low mark, the outputs change one clock later. If transmit DMA is enabled, `dma_tx_req` goes high and `stat_ae` stays low. Otherwise `stat_ae` goes high. Both outputs are low one clock after the condition stops.
- R9: When `xfer_active`=0 and the buffer is empty, all four watermark outputs are low one clock later, whatever the low mark is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_active | input | 1 | A data transfer is in progress |
| dir_rx | input | 1 | 1: card to host, 0: host to card |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Configuration read-back |
| cpu_wr | input | 1 | Processor data-register write |
| cpu_wdata | input | 16 | Processor write word |
| cpu_rd | input | 1 | Processor data-register read (pops the head) |
| card_push | input | 1 | Card side deposits a word |
| card_wdata | input | 16 | Card-side word |
| card_pop | input | 1 | Card side takes the head word |
| rd_data | output | 16 | Head word, or 0 when empty |
| fill_count | output | 6 | Occupancy, 0 to 32 |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |
| stat_af | output | 1 | High-mark status flag |
| stat_ae | output | 1 | Low-mark status flag |
| underrun | output | 1 | Sticky empty-read flag |

## Verification
There are two cases where two operations land on the same clock edge. The first is a fill and a drain together. The bench provokes this when the buffer is full, where the drop rule applies, when it is part full, and when it is empty, where the pop underruns while the push is still accepted. The second is a write to the configuration word together with a change in occupancy. Here the next watermark outputs must come from the old configuration and the old occupancy. A behavioural queue model in the bench applies these ordering rules on every edge and compares all outputs after each cycle.

// File: rtl/sdfw_pkg.sv
`timescale 1ns/1ps
package sdfw_pkg;
  localparam int CFG_W       = 16;
  localparam int LVL_W       = 5;
  localparam int RXEN_BIT    = 15;
  localparam int HI_LSB      = 8;
  localparam int TXEN_BIT    = 7;
  localparam int LO_LSB      = 0;

  typedef struct packed {
    logic             rx_en;
    logic [LVL_W-1:0] hi_mark;
    logic             tx_en;
    logic [LVL_W-1:0] lo_mark;
  } buf_cfg_t;

  localparam buf_cfg_t CFG_RST = '{rx_en: 1'b0, hi_mark: 5'h1F,
                                   tx_en: 1'b0, lo_mark: 5'h00};
endpackage

// File: rtl/sdfw_cfg_reg.sv
`timescale 1ns/1ps
module sdfw_cfg_reg
  import sdfw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output buf_cfg_t         cfg_q,
  output logic [CFG_W-1:0] cfg_rdata
);
  buf_cfg_t cfg_d;
  logic     unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_wdata[14:13], cfg_wdata[6:5]};

  always_comb begin
    cfg_d = cfg_q;
    if (cfg_we) begin
      cfg_d.rx_en   = cfg_wdata[RXEN_BIT];
      cfg_d.hi_mark = cfg_wdata[HI_LSB +: LVL_W];
      cfg_d.tx_en   = cfg_wdata[TXEN_BIT];
      cfg_d.lo_mark = cfg_wdata[LO_LSB +: LVL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RST;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    cfg_rdata                   = '0;
    cfg_rdata[RXEN_BIT]         = cfg_q.rx_en;
    cfg_rdata[HI_LSB +: LVL_W]  = cfg_q.hi_mark;
    cfg_rdata[TXEN_BIT]         = cfg_q.tx_en;
    cfg_rdata[LO_LSB +: LVL_W]  = cfg_q.lo_mark;
  end

  // R3: a written word reads back with only the defined fields kept
  assert_cfg_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_rdata == ($past(cfg_wdata) & 16'h9F9F)));
endmodule

// File: rtl/sdfw_store.sv
`timescale 1ns/1ps
module sdfw_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head_data,
  output logic [CW-1:0]    count_q,
  output logic             underrun_q
);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0]    count_d;
  logic             underrun_d;
  logic             do_push, do_pop, empty;

  assign empty   = (count_q == '0);
  assign do_push = push && (count_q != FULL);
  assign do_pop  = pop && !empty;

  always_comb begin
    wptr_d     = wptr_q;
    rptr_d     = rptr_q;
    count_d    = count_q;
    underrun_d = underrun_q;
    if (do_push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (do_pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    if (do_push && !do_pop)      count_d = count_q + 1'b1;
    else if (do_pop && !do_push) count_d = count_q - 1'b1;
    if (pop && empty) underrun_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q     <= '0;
      rptr_q     <= '0;
      count_q    <= '0;
      underrun_q <= 1'b0;
    end else begin
      wptr_q     <= wptr_d;
      rptr_q     <= rptr_d;
      count_q    <= count_d;
      underrun_q <= underrun_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= push_data;
  end

  assign head_data = empty ? '0 : mem[rptr_q];

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= FULL);
  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q == FULL && push && !pop) |=> (count_q == FULL));
  assert_underrun_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty) |=> underrun_q);
  assert_underrun_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underrun_q |=> underrun_q);
  assert_empty_pop_still_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (count_q == '0));
endmodule

// File: rtl/sdfw_watermark.sv
`timescale 1ns/1ps
module sdfw_watermark
  import sdfw_pkg::*;
#(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] count,
  input  buf_cfg_t      cfg,
  input  logic          dir_rx,
  input  logic          xfer_active,
  output logic          dma_rx_req,
  output logic          dma_tx_req,
  output logic          stat_af,
  output logic          stat_ae
);
  logic idle_empty, over_hi, under_lo;
  logic rx_d, tx_d, af_d, ae_d;

  always_comb begin
    idle_empty = !xfer_active && (count == '0);
    over_hi    = dir_rx && (count > CW'(cfg.hi_mark));
    under_lo   = !dir_rx && (count < CW'(cfg.lo_mark));
    rx_d = 1'b0;
    af_d = 1'b0;
    tx_d = 1'b0;
    ae_d = 1'b0;
    if (!idle_empty) begin
      rx_d = over_hi  &&  cfg.rx_en;
      af_d = over_hi  && !cfg.rx_en;
      tx_d = under_lo &&  cfg.tx_en;
      ae_d = under_lo && !cfg.tx_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_rx_req <= 1'b0;
      dma_tx_req <= 1'b0;
      stat_af    <= 1'b0;
      stat_ae    <= 1'b0;
    end else begin
      dma_rx_req <= rx_d;
      dma_tx_req <= tx_d;
      stat_af    <= af_d;
      stat_ae    <= ae_d;
    end
  end

  assert_rx_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_rx_req && stat_af));
  assert_tx_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_tx_req && stat_ae));
  assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_active && count == '0) |=>
      !(dma_rx_req || dma_tx_req || stat_af || stat_ae));
endmodule

// File: rtl/sd_fifo_wm.sv
`timescale 1ns/1ps
module sd_fifo_wm
  import sdfw_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int WIDTH = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    xfer_active,
  input  logic                    dir_rx,
  input  logic                    cfg_we,
  input  logic [CFG_W-1:0]        cfg_wdata,
  output logic [CFG_W-1:0]        cfg_rdata,
  input  logic                    cpu_wr,
  input  logic [WIDTH-1:0]        cpu_wdata,
  input  logic                    cpu_rd,
  input  logic                    card_push,
  input  logic [WIDTH-1:0]        card_wdata,
  input  logic                    card_pop,
  output logic [WIDTH-1:0]        rd_data,
  output logic [$clog2(DEPTH):0]  fill_count,
  output logic                    dma_rx_req,
  output logic                    dma_tx_req,
  output logic                    stat_af,
  output logic                    stat_ae,
  output logic                    underrun
);
  localparam int CW = $clog2(DEPTH) + 1;

  buf_cfg_t         cfg_q;
  logic             push, pop;
  logic [WIDTH-1:0] push_data;

  // direction routes the filling and draining strobes (R2)
  assign push      = dir_rx ? card_push  : cpu_wr;
  assign push_data = dir_rx ? card_wdata : cpu_wdata;
  assign pop       = dir_rx ? cpu_rd     : card_pop;

  sdfw_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_wdata (cfg_wdata),
    .cfg_q     (cfg_q),
    .cfg_rdata (cfg_rdata)
  );

  sdfw_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (push),
    .push_data  (push_data),
    .pop        (pop),
    .head_data  (rd_data),
    .count_q    (fill_count),
    .underrun_q (underrun)
  );

  sdfw_watermark #(.CW(CW)) u_wm (
    .clk         (clk),
    .rst_n       (rst_n),
    .count       (fill_count),
    .cfg         (cfg_q),
    .dir_rx      (dir_rx),
    .xfer_active (xfer_active),
    .dma_rx_req  (dma_rx_req),
    .dma_tx_req  (dma_tx_req),
    .stat_af     (stat_af),
    .stat_ae     (stat_ae)
  );
endmodule

// File: tb/sd_fifo_wm_tb.sv
`timescale 1ns/1ps
module sd_fifo_wm_tb;
  localparam int DEPTH = 32;

  logic        clk, rst_n;
  logic        xfer_active, dir_rx, cfg_we, cpu_wr, cpu_rd, card_push, card_pop;
  logic [15:0] cfg_wdata, cpu_wdata, card_wdata;
  logic [15:0] cfg_rdata, rd_data;
  logic [5:0]  fill_count;
  logic        dma_rx_req, dma_tx_req, stat_af, stat_ae, underrun;

  sd_fifo_wm u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .dir_rx(dir_rx),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
    .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
    .rd_data(rd_data), .fill_count(fill_count),
    .dma_rx_req(dma_rx_req), .dma_tx_req(dma_tx_req),
    .stat_af(stat_af), .stat_ae(stat_ae), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  int q[$];
  int m_cfg;
  bit m_rx, m_tx, m_af, m_ae, m_udf;

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge();
    int cnt = q.size();
    int hi  = (m_cfg >> 8) & 31;
    int lo  = m_cfg & 31;
    bit idle  = !xfer_active && cnt == 0;
    bit over  = dir_rx && cnt > hi;
    bit under = !dir_rx && cnt < lo;
    bit push, pop;
    int data;
    m_rx = !idle && over  &&  m_cfg[15];
    m_af = !idle && over  && !m_cfg[15];
    m_tx = !idle && under &&  m_cfg[7];
    m_ae = !idle && under && !m_cfg[7];
    push = dir_rx ? card_push : cpu_wr;
    data = dir_rx ? int'(card_wdata) : int'(cpu_wdata);
    pop  = dir_rx ? cpu_rd : card_pop;
    if (pop) begin
      if (cnt == 0) m_udf = 1;
      else void'(q.pop_front());
    end
    if (push && cnt < DEPTH) q.push_back(data);
    if (cfg_we) m_cfg = int'(cfg_wdata) & 16'h9F9F;
  endtask

  task automatic compare_all();
    chk("R1", "fill_count", int'(fill_count), q.size());
    chk("R5", "rd_data", int'(rd_data), (q.size() > 0) ? q[0] : 0);
    chk("R3", "cfg_rdata", int'(cfg_rdata), m_cfg);
    chk("R7", "dma_rx_req", int'(dma_rx_req), int'(m_rx));
    chk("R7", "stat_af", int'(stat_af), int'(m_af));
    chk("R8", "dma_tx_req", int'(dma_tx_req), int'(m_tx));
    chk("R8", "stat_ae", int'(stat_ae), int'(m_ae));
    chk("R6", "underrun", int'(underrun), int'(m_udf));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    cfg_we = 0; cpu_wr = 0; cpu_rd = 0; card_push = 0; card_pop = 0;
  endtask

  task automatic set_cfg(int v);
    cfg_we = 1; cfg_wdata = 16'(v); step();
  endtask

  task automatic cpu_write(int v);
    cpu_wr = 1; cpu_wdata = 16'(v); step();
  endtask

  task automatic card_write(int v);
    card_push = 1; card_wdata = 16'(v); step();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; xfer_active = 0; dir_rx = 0; cfg_we = 0; cpu_wr = 0; cpu_rd = 0;
    card_push = 0; card_pop = 0; cfg_wdata = 0; cpu_wdata = 0; card_wdata = 0;
    m_cfg = 16'h1F00; m_rx = 0; m_tx = 0; m_af = 0; m_ae = 0; m_udf = 0;
    repeat (3) @(negedge clk);
    // R3 reset value, plus the empty state
    chk("R3", "reset cfg_rdata", int'(cfg_rdata), 16'h1F00);
    compare_all();
    rst_n = 1;

    // host to card: low-mark status, then transmit DMA
    xfer_active = 1; dir_rx = 0;
    set_cfg(16'h0004);
    for (int i = 0; i < 3; i++) cpu_write(16'hA000 + i);
    set_cfg(16'hFFE4);                   // unused bits must read back 0 (R3)
    for (int i = 3; i < DEPTH + 1; i++) cpu_write(16'hA000 + i);
    chk("R4", "count after write beyond full", int'(fill_count), 32);
    card_write(16'h5555);                // not selected side in this direction
    chk("R2", "card push ignored when dir_rx=0", int'(fill_count), 32);
    cpu_wr = 1; cpu_wdata = 16'hBEEF; card_pop = 1; step();
    chk("R4", "push+pop at full", int'(fill_count), 31);
    cpu_rd = 1; step();                  // not selected side in this direction
    chk("R2", "cpu read ignored when dir_rx=0", int'(fill_count), 31);
    for (int i = 0; i < 31; i++) begin card_pop = 1; step(); end
    card_pop = 1; cpu_wr = 1; cpu_wdata = 16'h1234; step();
    chk("R6", "underrun after empty pop", int'(underrun), 1);
    chk("R6", "push beside empty pop kept", int'(fill_count), 1);
    card_pop = 1; step();

    // card to host: high-mark status, then receive DMA
    dir_rx = 1;
    set_cfg(16'h0300);
    for (int i = 0; i < 5; i++) card_write(16'hC000 + i);
    set_cfg(16'h8300);
    card_push = 1; card_wdata = 16'hC100; cpu_rd = 1; step();
    for (int i = 0; i < 6; i++) begin cpu_rd = 1; step(); end
    step();

    // idle and empty overrides the low mark
    dir_rx = 0; xfer_active = 0;
    set_cfg(16'h0005);
    step(); step();
    chk("R9", "stat_ae when idle and empty", int'(stat_ae), 0);
    xfer_active = 1; step(); step();
    xfer_active = 0; step();

    // mixed traffic with wrap-around
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom;
      xfer_active = (r % 8) != 0;
      if ((i % 97) == 0) dir_rx = ~dir_rx;
      card_push  = r[4] | r[5];
      card_wdata = 16'(r >> 8);
      cpu_wr     = r[6] | r[7];
      cpu_wdata  = 16'(r >> 12);
      cpu_rd     = r[24] & (r[25] | (i[8]));
      card_pop   = r[26] & (r[27] | (i[8]));
      if ((r % 61) == 0) begin cfg_we = 1; cfg_wdata = 16'($urandom); end
      step();
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule